// File: doc/BRIEF.md
# DMA Master Region Protection Checker

This block sits beside the bus paths of two DMA masters and decides, in the same cycle as each request, whether the access may proceed. Every address is compared against one shared table of programmable regions. Each region has a power-of-two size and a base aligned to that size. For each master, a region has its own enable bit, read-off bit and write-off bit. An address that hits no enabled region falls back to per-master background read-off and write-off bits.

A blocked access is always dropped. Each master also selects what else happens: nothing more, a bus-error pulse, a non-maskable interrupt pulse, or a system reset request. A sticky per-master violation flag records every blocked access, and software clears it through a dedicated clear register. All configuration registers are guarded by a key register, so software must unlock them before it can change the protection setup.

Top module: `dma_region_guard`

## Requirements
- R1: After reset the configuration is locked. Writing 0x96A5 to the key register (address 0) unlocks it and writing 0x96A4 locks it again. Any other value written there changes nothing. Bit 0 of the key register reads 1 while unlocked. While locked, writes to the control, base and attribute registers are ignored.
- R2: A region with size code c covers 2^(c+1) bytes, and codes below 4 are treated as 4. An address matches when all its bits above bit c equal those of the base, so the low c+1 bits of the base are ignored. Code 31 covers the whole address space.
- R3: Each region has a per-master enable bit. A region whose enable bit is 0 never matches for that master.
- R4: A matching region permits a read when its read-off bit for that master is 0, and permits a write when its write-off bit is 0.
- R5: When no enabled region matches, the master's background read-off or write-off bit decides. After reset every background bit is 0, which permits the access.
- R6: When several enabled regions match, the access is blocked if any of them blocks that access type. The background bits are not used when at least one region matches.
- R7: m_grant and m_block are combinational from the request and change in the same cycle as it. Exactly one of them is high while m_valid is high, and both are low while m_valid is low.
- R8: The action of master m sits at control bits [8m+1:8m]. Code 0 drops the access with no pulse. Code 1 pulses err_bus[m]. Code 2 pulses err_nmi. Code 3 pulses err_reset. Each pulse lasts one cycle and appears in the cycle after the blocked access.
- R9: Status register bit m (address 2) is set by any blocked access of master m and stays set. Writing 1 to bit m of the clear register (address 3) clears it, whether or not the configuration is locked. A new violation in the same cycle as a clear wins.
- R10: The register address is {bank[1:0], index}. Bank 0 holds the key register (index 0), control (1), status (2) and clear (3). Control bits [8m+2] and [8m+3] are the background read-off and write-off bits. Bank 2 holds the raw base of region index. Bank 3 holds the attribute register: size code in [4:0], and for master m enable at [8+4m], read-off at [9+4m] and write-off at [10+4m]. Reads return the values last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_valid | input | NUM_MASTERS | Access request per master |
| m_addr | input | NUM_MASTERS*ADDR_W | Byte address per master, master m at [m*ADDR_W +: ADDR_W] |
| m_write | input | NUM_MASTERS | 1 for write, 0 for read |
| m_grant | output | NUM_MASTERS | Access permitted |
| m_block | output | NUM_MASTERS | Access blocked |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | IDX_W+2 | Register address {bank, index} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| err_bus | output | NUM_MASTERS | Bus-error pulse per master |
| err_nmi | output | 1 | Non-maskable interrupt pulse |
| err_reset | output | 1 | System reset request pulse |

## Verification
The bench builds the block with 4 regions, 2 masters and a 12-bit address. At that size every one of the 4096 addresses can be swept, for both masters and both access types, under two region tables. The first table has nested regions, a clamped size code, a misaligned base and regions enabled for one master only. The second has a single region with size code 31 that covers the whole space. Because the address space is this small, the bench can compute every expected grant or block from the programmed values and compare it with the outputs. Directed steps then cover the lock, the one-cycle pulse of each action code and the clearing of the sticky flags.

// File: rtl/dmg_pkg.sv
package dmg_pkg;
    localparam int DATA_W   = 32;
    localparam int MIN_CODE = 4;
    localparam logic [DATA_W-1:0] KEY_OPEN = 32'h0000_96A5;
    localparam logic [DATA_W-1:0] KEY_SHUT = 32'h0000_96A4;

    typedef enum logic [1:0] {
        ACT_DROP   = 2'd0,
        ACT_BUSERR = 2'd1,
        ACT_NMI    = 2'd2,
        ACT_RESET  = 2'd3
    } act_e;

    // per-master permission of one region
    typedef struct packed {
        logic en;
        logic rd_off;
        logic wr_off;
    } perm_t;

    // per-master control: action and background permissions
    typedef struct packed {
        act_e act;
        logic bg_rd_off;
        logic bg_wr_off;
    } mctl_t;
endpackage

// File: rtl/dmg_region_match.sv
module dmg_region_match
    import dmg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [4:0]        code,
    input  perm_t             perm,
    output logic              hit,
    output logic              rd_off,
    output logic              wr_off
);
    logic [4:0]        eff_code;
    logic [ADDR_W-1:0] keep;

    always_comb begin
        eff_code = (code < 5'(MIN_CODE)) ? 5'(MIN_CODE) : code;
        // bit i takes part in the compare only above the region span
        for (int i = 0; i < ADDR_W; i++) begin
            keep[i] = (i > int'(eff_code));
        end
        hit    = perm.en && (((addr ^ base) & keep) == '0);
        rd_off = perm.rd_off;
        wr_off = perm.wr_off;
    end
endmodule

// File: rtl/dmg_master_check.sv
module dmg_master_check
    import dmg_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 valid,
    input  logic                                 write,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]   base,
    input  logic [NUM_REGIONS-1:0][4:0]          code,
    input  perm_t [NUM_REGIONS-1:0]              perm,
    input  mctl_t                                ctl,
    output logic                                 grant,
    output logic                                 block
);
    logic [NUM_REGIONS-1:0] hit;
    logic [NUM_REGIONS-1:0] rd_off;
    logic [NUM_REGIONS-1:0] wr_off;
    logic                   any_hit;
    logic                   hit_deny;
    logic                   bg_deny;
    logic                   viol;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        dmg_region_match #(.ADDR_W(ADDR_W)) u_match (
            .addr   (addr),
            .base   (base[r]),
            .code   (code[r]),
            .perm   (perm[r]),
            .hit    (hit[r]),
            .rd_off (rd_off[r]),
            .wr_off (wr_off[r])
        );
    end

    always_comb begin
        any_hit  = |hit;
        hit_deny = write ? |(hit & wr_off) : |(hit & rd_off);
        bg_deny  = write ? ctl.bg_wr_off : ctl.bg_rd_off;
        viol     = any_hit ? hit_deny : bg_deny;
        grant    = valid & ~viol;
        block    = valid & viol;
    end

    // R5: a read that hits nothing follows the background read bit
    a_r5_background_read: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !write && (hit == '0) && ctl.bg_rd_off) |-> block);

    // R6: one denying region wins over any number of permitting ones
    a_r6_any_deny_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write && ((hit & wr_off) != '0)) |-> block);

    // R4: a hit with no read-off bit set lets the read through
    a_r4_read_permitted: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !write && (hit != '0) && ((hit & rd_off) == '0)) |-> grant);
endmodule

// File: rtl/dmg_cfg_regs.sv
module dmg_cfg_regs
    import dmg_pkg::*;
#(
    parameter int NUM_MASTERS = 2,
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cfg_we,
    input  logic [IDX_W+1:0]                              cfg_addr,
    input  logic [DATA_W-1:0]                             cfg_wdata,
    output logic [DATA_W-1:0]                             cfg_rdata,
    input  logic [NUM_MASTERS-1:0]                        viol_set,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]            base_o,
    output logic [NUM_REGIONS-1:0][4:0]                   code_o,
    output perm_t [NUM_MASTERS-1:0][NUM_REGIONS-1:0]      perm_o,
    output mctl_t [NUM_MASTERS-1:0]                       ctl_o
);
    localparam logic [1:0]       BK_MISC = 2'd0;
    localparam logic [1:0]       BK_BASE = 2'd2;
    localparam logic [1:0]       BK_ATTR = 2'd3;
    localparam logic [IDX_W-1:0] IX_KEY  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IX_CTL  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IX_FLAG = IDX_W'(2);
    localparam logic [IDX_W-1:0] IX_CLR  = IDX_W'(3);

    typedef struct packed {
        logic                                     open;
        logic [NUM_MASTERS-1:0]                   flag;
        mctl_t [NUM_MASTERS-1:0]                  ctl;
        logic [NUM_REGIONS-1:0][ADDR_W-1:0]       base;
        logic [NUM_REGIONS-1:0][4:0]              code;
        perm_t [NUM_MASTERS-1:0][NUM_REGIONS-1:0] perm;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [1:0]       bank;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;

    assign {bank, idx} = cfg_addr;
    assign idx_ok      = (int'(idx) < NUM_REGIONS);

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (bank)
                BK_MISC: begin
                    if (idx == IX_KEY) begin
                        if (cfg_wdata == KEY_OPEN)      cfg_d.open = 1'b1;
                        else if (cfg_wdata == KEY_SHUT) cfg_d.open = 1'b0;
                    end else if (idx == IX_CTL && cfg_q.open) begin
                        for (int m = 0; m < NUM_MASTERS; m++) begin
                            cfg_d.ctl[m].act       = act_e'(cfg_wdata[8*m +: 2]);
                            cfg_d.ctl[m].bg_rd_off = cfg_wdata[8*m + 2];
                            cfg_d.ctl[m].bg_wr_off = cfg_wdata[8*m + 3];
                        end
                    end else if (idx == IX_CLR) begin
                        cfg_d.flag = cfg_q.flag & ~cfg_wdata[NUM_MASTERS-1:0];
                    end
                end
                BK_BASE: begin
                    if (cfg_q.open && idx_ok) cfg_d.base[idx] = cfg_wdata[ADDR_W-1:0];
                end
                BK_ATTR: begin
                    if (cfg_q.open && idx_ok) begin
                        cfg_d.code[idx] = cfg_wdata[4:0];
                        for (int m = 0; m < NUM_MASTERS; m++) begin
                            cfg_d.perm[m][idx].en     = cfg_wdata[8 + 4*m];
                            cfg_d.perm[m][idx].rd_off = cfg_wdata[9 + 4*m];
                            cfg_d.perm[m][idx].wr_off = cfg_wdata[10 + 4*m];
                        end
                    end
                end
                default: ;
            endcase
        end
        // a fresh violation outranks a clear in the same cycle
        cfg_d.flag = cfg_d.flag | viol_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        cfg_rdata = '0;
        case (bank)
            BK_MISC: begin
                if (idx == IX_KEY) begin
                    cfg_rdata[0] = cfg_q.open;
                end else if (idx == IX_CTL) begin
                    for (int m = 0; m < NUM_MASTERS; m++) begin
                        cfg_rdata[8*m +: 2] = cfg_q.ctl[m].act;
                        cfg_rdata[8*m + 2]  = cfg_q.ctl[m].bg_rd_off;
                        cfg_rdata[8*m + 3]  = cfg_q.ctl[m].bg_wr_off;
                    end
                end else if (idx == IX_FLAG) begin
                    cfg_rdata[NUM_MASTERS-1:0] = cfg_q.flag;
                end
            end
            BK_BASE: begin
                if (idx_ok) cfg_rdata[ADDR_W-1:0] = cfg_q.base[idx];
            end
            BK_ATTR: begin
                if (idx_ok) begin
                    cfg_rdata[4:0] = cfg_q.code[idx];
                    for (int m = 0; m < NUM_MASTERS; m++) begin
                        cfg_rdata[8 + 4*m]  = cfg_q.perm[m][idx].en;
                        cfg_rdata[9 + 4*m]  = cfg_q.perm[m][idx].rd_off;
                        cfg_rdata[10 + 4*m] = cfg_q.perm[m][idx].wr_off;
                    end
                end
            end
            default: ;
        endcase
    end

    assign base_o = cfg_q.base;
    assign code_o = cfg_q.code;
    assign perm_o = cfg_q.perm;
    assign ctl_o  = cfg_q.ctl;

    // R1: region table frozen while locked
    a_r1_locked_table: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.open && cfg_we && bank != BK_MISC)
        |=> ($stable(cfg_q.base) && $stable(cfg_q.code) && $stable(cfg_q.perm)));

    // R1: control register frozen while locked
    a_r1_locked_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.open && cfg_we && bank == BK_MISC && idx == IX_CTL) |=> $stable(cfg_q.ctl));

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_flag_chk
        // R9: flag only drops on an explicit clear
        a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q.flag[m] && !(cfg_we && bank == BK_MISC && idx == IX_CLR && cfg_wdata[m]))
            |=> cfg_q.flag[m]);
        // R9: every violation leaves the flag set
        a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            viol_set[m] |=> cfg_q.flag[m]);
    end
endmodule

// File: rtl/dma_region_guard.sv
module dma_region_guard
    import dmg_pkg::*;
#(
    parameter  int NUM_MASTERS = 2,
    parameter  int NUM_REGIONS = 16,
    parameter  int ADDR_W      = 32,
    localparam int IDX_W       = (NUM_REGIONS > 4) ? $clog2(NUM_REGIONS) : 2,
    localparam int CFG_AW      = IDX_W + 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_MASTERS-1:0]          m_valid,
    input  logic [NUM_MASTERS*ADDR_W-1:0]   m_addr,
    input  logic [NUM_MASTERS-1:0]          m_write,
    output logic [NUM_MASTERS-1:0]          m_grant,
    output logic [NUM_MASTERS-1:0]          m_block,
    input  logic                            cfg_we,
    input  logic [CFG_AW-1:0]               cfg_addr,
    input  logic [DATA_W-1:0]               cfg_wdata,
    output logic [DATA_W-1:0]               cfg_rdata,
    output logic [NUM_MASTERS-1:0]          err_bus,
    output logic                            err_nmi,
    output logic                            err_reset
);
    typedef struct packed {
        logic [NUM_MASTERS-1:0] bus;
        logic                   nmi;
        logic                   rst;
    } ev_t;

    logic [NUM_REGIONS-1:0][ADDR_W-1:0]       base;
    logic [NUM_REGIONS-1:0][4:0]              code;
    perm_t [NUM_MASTERS-1:0][NUM_REGIONS-1:0] perm;
    mctl_t [NUM_MASTERS-1:0]                  ctl;
    ev_t                                      ev_d, ev_q;

    dmg_cfg_regs #(
        .NUM_MASTERS (NUM_MASTERS),
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .viol_set  (m_block),
        .base_o    (base),
        .code_o    (code),
        .perm_o    (perm),
        .ctl_o     (ctl)
    );

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
        dmg_master_check #(
            .NUM_REGIONS (NUM_REGIONS),
            .ADDR_W      (ADDR_W)
        ) u_check (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (m_valid[m]),
            .write (m_write[m]),
            .addr  (m_addr[m*ADDR_W +: ADDR_W]),
            .base  (base),
            .code  (code),
            .perm  (perm[m]),
            .ctl   (ctl[m]),
            .grant (m_grant[m]),
            .block (m_block[m])
        );

        // R8: a bus-error pulse always follows a blocked access of this master
        a_r8_bus_cause: assert property (@(posedge clk) disable iff (!rst_n)
            err_bus[m] |-> $past(m_block[m]));
    end

    always_comb begin
        ev_d = '0;
        for (int m = 0; m < NUM_MASTERS; m++) begin
            if (m_block[m]) begin
                case (ctl[m].act)
                    ACT_BUSERR: ev_d.bus[m] = 1'b1;
                    ACT_NMI:    ev_d.nmi    = 1'b1;
                    ACT_RESET:  ev_d.rst    = 1'b1;
                    default:    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign err_bus   = ev_q.bus;
    assign err_nmi   = ev_q.nmi;
    assign err_reset = ev_q.rst;

    // R8: interrupt and reset pulses need a blocked access one cycle earlier
    a_r8_nmi_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_nmi |-> $past(m_block != '0));
    a_r8_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_reset |-> $past(m_block != '0));
    // R7: no decision without a request
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_grant | m_block) & ~m_valid) == '0);
endmodule

// File: tb/dma_region_guard_tb.sv
`timescale 1ns/1ps
module dma_region_guard_tb;
    localparam int NM  = 2;
    localparam int NR  = 4;
    localparam int AW  = 12;
    localparam int CAW = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NM-1:0]      m_valid;
    logic [NM*AW-1:0]   m_addr;
    logic [NM-1:0]      m_write;
    logic [NM-1:0]      m_grant;
    logic [NM-1:0]      m_block;
    logic               cfg_we;
    logic [CAW-1:0]     cfg_addr;
    logic [31:0]        cfg_wdata;
    logic [31:0]        cfg_rdata;
    logic [NM-1:0]      err_bus;
    logic               err_nmi;
    logic               err_reset;

    always #2.5 clk = ~clk;

    dma_region_guard #(.NUM_MASTERS(NM), .NUM_REGIONS(NR), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_addr(m_addr), .m_write(m_write),
        .m_grant(m_grant), .m_block(m_block), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .err_bus(err_bus),
        .err_nmi(err_nmi), .err_reset(err_reset)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int mb_base [NR];
    int mb_code [NR];
    bit mb_en   [NM][NR];
    bit mb_rd   [NM][NR];
    bit mb_wr   [NM][NR];
    bit bg_rd   [NM];
    bit bg_wr   [NM];

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic cfg_wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CAW'(a); cfg_wdata = 32'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(int a, output logic [31:0] d);
        cfg_addr = CAW'(a);
        #1;
        d = cfg_rdata;
    endtask

    task automatic set_region(int r, int b, int c, bit e0, bit r0, bit w0, bit e1, bit r1, bit w1);
        cfg_wr(8 + r, b);
        cfg_wr(12 + r, c | (int'(e0) << 8) | (int'(r0) << 9) | (int'(w0) << 10)
                         | (int'(e1) << 12) | (int'(r1) << 13) | (int'(w1) << 14));
        mb_base[r] = b & ((1 << AW) - 1);
        mb_code[r] = c;
        mb_en[0][r] = e0; mb_rd[0][r] = r0; mb_wr[0][r] = w0;
        mb_en[1][r] = e1; mb_rd[1][r] = r1; mb_wr[1][r] = w1;
    endtask

    // expected decision computed from the requirement text
    function automatic bit exp_block(int m, int a, bit w);
        bit any = 0;
        bit dn  = 0;
        for (int r = 0; r < NR; r++) begin
            if (mb_en[m][r]) begin
                int ec = (mb_code[r] < 4) ? 4 : mb_code[r];
                int sh = ec + 1;
                if (sh >= AW || ((a >> sh) == (mb_base[r] >> sh))) begin
                    any = 1;
                    if (w ? mb_wr[m][r] : mb_rd[m][r]) dn = 1;
                end
            end
        end
        return any ? dn : (w ? bg_wr[m] : bg_rd[m]);
    endfunction

    task automatic probe(int m, int a, bit w, bit exp_blk, string tag);
        @(negedge clk);
        m_valid = '0; m_write = '0; m_addr = '0;
        m_valid[m] = 1'b1; m_write[m] = w; m_addr[m*AW +: AW] = AW'(a);
        #1;
        chk(tag, {30'd0, m_block[m], m_grant[m]}, {30'd0, exp_blk, ~exp_blk});
        m_valid = '0;
    endtask

    task automatic sweep(string tag);
        for (int m = 0; m < NM; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int a = 0; a < (1 << AW); a++) begin
                    bit e;
                    m_valid = '0; m_write = '0; m_addr = '0;
                    m_valid[m] = 1'b1; m_write[m] = w[0]; m_addr[m*AW +: AW] = AW'(a);
                    #1;
                    e = exp_block(m, a, w[0]);
                    chk($sformatf("%s m%0d w%0d a=0x%0h", tag, m, w, a),
                        {30'd0, m_block[m], m_grant[m]}, {30'd0, e, ~e});
                end
            end
        end
        m_valid = '0;
    endtask

    task automatic fire(int m, int a, bit w);
        @(negedge clk);
        m_valid = '0; m_write = '0; m_addr = '0;
        m_valid[m] = 1'b1; m_write[m] = w; m_addr[m*AW +: AW] = AW'(a);
        @(negedge clk);
        m_valid = '0;
    endtask

    function automatic logic [31:0] events();
        return {28'd0, err_bus, err_nmi, err_reset};
    endfunction

    initial begin
        logic [31:0] v;
        m_valid = '0; m_addr = '0; m_write = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        for (int r = 0; r < NR; r++) begin
            mb_base[r] = 0; mb_code[r] = 0;
            for (int m = 0; m < NM; m++) begin
                mb_en[m][r] = 0; mb_rd[m][r] = 0; mb_wr[m][r] = 0;
            end
        end
        for (int m = 0; m < NM; m++) begin bg_rd[m] = 0; bg_wr[m] = 0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cfg_rd(0, v);  chk("R1 reset locked", v, 0);
        cfg_rd(2, v);  chk("R9 reset flags clear", v, 0);
        chk("R8 reset no events", events(), 0);
        probe(0, 'h123, 0, 0, "R5 reset background permits");
        probe(1, 'h123, 1, 0, "R5 reset background permits write");

        // R1 lock behaviour
        cfg_wr(1, 'h0101);   cfg_rd(1, v); chk("R1 locked ctl write ignored", v, 0);
        cfg_wr(8, 'h0ABC);   cfg_rd(8, v); chk("R1 locked base write ignored", v, 0);
        cfg_wr(0, 'h1234);   cfg_rd(0, v); chk("R1 wrong key keeps lock", v, 0);
        cfg_wr(0, 'h96A5);   cfg_rd(0, v); chk("R1 unlock key", v, 1);

        // table A: m0 bus error, m1 NMI with background read off
        cfg_wr(1, 'h0601);
        bg_rd[1] = 1;
        cfg_rd(1, v); chk("R10 control readback", v, 'h0601);
        set_region(0, 'h100, 6, 1, 0, 0, 1, 0, 0);
        set_region(1, 'h140, 4, 1, 0, 1, 1, 0, 0);
        set_region(2, 'h8F3, 9, 1, 0, 0, 1, 1, 0);
        set_region(3, 'h000, 2, 0, 0, 0, 1, 1, 1);
        cfg_rd(10, v); chk("R10 raw base readback", v, 'h8F3);
        cfg_rd(14, v); chk("R10 attribute readback", v, 'h3109);

        cfg_wr(0, 'h96A4);   cfg_rd(0, v); chk("R1 lock key", v, 0);
        cfg_wr(8, 'h555);    cfg_rd(8, v); chk("R1 relocked base unchanged", v, 'h100);
        cfg_wr(1, 'h0000);   cfg_rd(1, v); chk("R1 relocked ctl unchanged", v, 'h0601);

        probe(1, 'h8FF, 0, 1, "R2 low base bits ignored, inside span");
        probe(1, 'hBFF, 1, 0, "R2 top of span write permitted");
        probe(1, 'h01F, 1, 1, "R2 clamped code covers 32 bytes");
        probe(1, 'h020, 1, 0, "R2 clamped code ends at 32 bytes");
        probe(0, 'h010, 1, 0, "R3 region disabled for master 0");
        probe(0, 'h150, 1, 1, "R6 nested deny wins");
        probe(0, 'h160, 1, 0, "R6 outer region only permits");
        probe(0, 'h150, 0, 0, "R4 read-off zero permits read");
        probe(1, 'h7FF, 0, 1, "R5 background read off blocks");

        sweep("R2 R3 R4 R5 R6 R7 table A");

        // R8 and R9 with table A
        cfg_wr(3, 3);
        cfg_rd(2, v); chk("R9 clear after sweep", v, 0);
        fire(0, 'h140, 1);
        chk("R8 bus error pulse", events(), 'b0100);
        @(negedge clk);
        chk("R8 bus error single cycle", events(), 0);
        cfg_rd(2, v); chk("R9 sticky flag master 0", v, 1);
        fire(1, 'h800, 0);
        chk("R8 nmi pulse", events(), 'b0010);
        @(negedge clk);
        chk("R8 nmi single cycle", events(), 0);
        cfg_rd(2, v); chk("R9 both flags set", v, 3);
        cfg_wr(3, 1);
        cfg_rd(2, v); chk("R9 clear bit 0 while locked", v, 2);
        fire(0, 'h140, 0);
        chk("R8 granted access no event", events(), 0);
        cfg_rd(2, v); chk("R9 granted access sets no flag", v, 2);
        cfg_wr(3, 2);
        cfg_rd(2, v); chk("R9 clear bit 1", v, 0);

        // table B: one region over the whole space
        cfg_wr(0, 'h96A5);
        cfg_wr(1, 'h0803);
        bg_rd[1] = 0; bg_wr[1] = 1;
        set_region(0, 'h000, 31, 1, 0, 1, 0, 0, 0);
        for (int r = 1; r < NR; r++) set_region(r, 0, 0, 0, 0, 0, 0, 0, 0);
        cfg_wr(0, 'h96A4);
        probe(0, 'hFFF, 1, 1, "R2 code 31 covers top address");
        sweep("R2 R3 R5 R6 R7 table B");

        cfg_wr(3, 3);
        fire(0, 'h555, 1);
        chk("R8 reset request pulse", events(), 'b0001);
        @(negedge clk);
        chk("R8 reset single cycle", events(), 0);
        fire(1, 'h777, 1);
        chk("R8 drop action no pulse", events(), 0);
        cfg_rd(2, v); chk("R9 drop action still flags", v, 3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule